// File: doc/BRIEF.md
# Sequential Shared-Adder Vector Adder

This block adds two short vectors one element at a time through a single adder. Two input banks hold the operand vectors A and B. Each bank is loaded in parallel from its input bus while the block is idle. A start pulse launches a run. A small controller then steps an element index from 0 upward, one step per clock. The index picks the matching A and B elements through two selectors, and it enables exactly one output register, which captures their sum.

After the last element is stored, the block drops its busy flag and raises done for one cycle. The result vector can then be read from the output bus. The element width and the vector length are parameters, and each sum wraps modulo 2^W. A start pulse that arrives while a run is under way has no effect.

Top module: `vec_add_seq`

## Requirements
- R1: After reset, c_out is all zeros, and busy and done are both 0.
- R2: A start seen at a rising edge while busy is 0 sets busy at that edge. Busy then stays high for exactly N clock cycles, with N = 4 by default.
- R3: Element i occupies bits [i*W +: W] of a_in, b_in and c_out. At the end of a run, element i of c_out equals (A[i] + B[i]) mod 2^W.
- R4: In the k-th busy cycle (k counted from 0), only element k of c_out is written. The first edge after start writes element 0, and the next edge writes element 1. All other elements keep their values.
- R5: The edge that writes the last element also clears busy and sets done. Done is high for exactly one cycle.
- R6: A start that arrives while busy is 1 is ignored. The run still ends after N busy cycles with a single done pulse.
- R7: A sum that exceeds 2^W - 1 keeps only its low W bits, for example 0xFF + 0x02 = 0x01 at W = 8.
- R8: load_a and load_b capture a_in and b_in at a rising edge. While busy is 0, neither load changes c_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when idle |
| load_a | input | 1 | Captures a_in into the A bank |
| a_in | input | N*W | Packed A vector, element i at [i*W +: W] |
| load_b | input | 1 | Captures b_in into the B bank |
| b_in | input | N*W | Packed B vector |
| c_out | output | N*W | Packed result vector |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the last element is stored |

## Verification
The sum-capture assertion compares each written result with the operands that were present in the previous cycle. It therefore assumes that the A and B banks are not reloaded during a run. The bench only loads the banks while busy is 0.

The stability assertions assume that the loads never touch the C bank, and that a start pulse is the only way to leave idle. The bench drives every input on the falling edge, so each input is settled for a full half-cycle before the edge that samples it.

// File: rtl/vec_add_seq.sv
module vec_add_seq #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           load_a,
  input  logic [N*W-1:0] a_in,
  input  logic           load_b,
  input  logic [N*W-1:0] b_in,
  output logic [N*W-1:0] c_out,
  output logic           busy,
  output logic           done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0]   a_q [N];
  logic [W-1:0]   b_q [N];
  logic [N*W-1:0] a_vec, b_vec;
  logic [IW-1:0]  idx;
  logic [N-1:0]   wen;
  logic [W-1:0]   sum;
  logic           last;

  assign sum  = a_q[idx] + b_q[idx];
  assign last = (idx == IW'(N - 1));

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign wen[g] = busy && (idx == IW'(g));
    assign a_vec[g*W +: W] = a_q[g];
    assign b_vec[g*W +: W] = b_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
        c_out[g*W +: W] <= '0;
      end else begin
        if (load_a) a_q[g] <= a_in[g*W +: W];
        if (load_b) b_q[g] <= b_in[g*W +: W];
        if (wen[g]) c_out[g*W +: W] <= sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= busy && last;
      if (!busy) begin
        idx  <= '0;
        busy <= start;
      end else if (last) begin
        idx  <= '0;
        busy <= 1'b0;
      end else begin
        idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_add_seq_chk.sv
module vec_add_seq_chk #(
  parameter int W = 8,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [N*W-1:0] a_vec,
  input logic [N*W-1:0] b_vec,
  input logic [N*W-1:0] c_out,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW+1:0]  cnt;
  logic [N*W-1:0] c_prev;
  logic [IW-1:0]  idx_prev;
  logic           seen;
  logic [W-1:0]   exp_sum;
  logic [W-1:0]   got;
  logic           others_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      c_prev   <= '0;
      idx_prev <= '0;
      exp_sum  <= '0;
      seen     <= 1'b0;
    end else begin
      cnt      <= busy ? cnt + 1'b1 : '0;
      c_prev   <= c_out;
      idx_prev <= idx;
      exp_sum  <= a_vec[idx*W +: W] + b_vec[idx*W +: W];
      seen     <= 1'b1;
    end
  end

  assign got = c_out[idx_prev*W +: W];

  always_comb begin
    others_held = 1'b1;
    for (int i = 0; i < N; i++)
      if (IW'(i) != idx_prev && c_out[i*W +: W] != c_prev[i*W +: W])
        others_held = 1'b0;
  end

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == (IW+2)'(N));
  a_r3_sum_stored: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(busy) |-> got == exp_sum);
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(busy) |-> others_held);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && seen && $past(busy));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(c_out));
endmodule

bind vec_add_seq vec_add_seq_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .a_vec(a_vec), .b_vec(b_vec), .c_out(c_out), .idx(idx)
);

// File: tb/vec_add_seq_tb.sv
module vec_add_seq_tb;
  localparam int W = 8;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, start = 0, load_a = 0, load_b = 0;
  logic [N*W-1:0] a_in = '0, b_in = '0;
  logic [N*W-1:0] c_out;
  logic busy, done;
  logic [N*W-1:0] ea, eb, ec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vec_add_seq #(.W(W), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_a(load_a), .a_in(a_in),
    .load_b(load_b), .b_in(b_in), .c_out(c_out), .busy(busy), .done(done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 c_out", 64'(c_out), 64'(0));
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
    ec = '0;
  endtask

  task automatic t_load(logic [N*W-1:0] a, logic [N*W-1:0] b);
    a_in = a; b_in = b; load_a = 1; load_b = 1;
    @(negedge clk);
    load_a = 0; load_b = 0;
    ea = a; eb = b;
    chk("R8 load leaves c_out", 64'(c_out), 64'(ec));
    @(negedge clk);
    chk("R8 idle c_out stable", 64'(c_out), 64'(ec));
  endtask

  task automatic t_run(bit extra_start, string tag);
    start = 1;
    @(negedge clk);
    start = extra_start;
    chk({tag, " R2 busy set"}, 64'(busy), 64'(1));
    chk({tag, " R4 nothing written yet"}, 64'(c_out), 64'(ec));
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (k == N - 2) start = 0;
      ec[k*W +: W] = ea[k*W +: W] + eb[k*W +: W];
      chk({tag, " R4 element order"}, 64'(c_out), 64'(ec));
      if (k < N - 1) begin
        chk({tag, " R2 busy held"}, 64'(busy), 64'(1));
        chk({tag, extra_start ? " R6 no early done" : " R5 no early done"}, 64'(done), 64'(0));
      end
    end
    chk({tag, " R5 done"}, 64'(done), 64'(1));
    chk({tag, " R5 busy cleared"}, 64'(busy), 64'(0));
    chk({tag, " R3 result"}, 64'(c_out), 64'(ec));
    @(negedge clk);
    chk({tag, " R5 done one cycle"}, 64'(done), 64'(0));
    chk({tag, extra_start ? " R6 no restart" : " R2 idle"}, 64'(busy), 64'(0));
  endtask

  task automatic t_wrap();
    t_load({8'h05, 8'h7f, 8'h80, 8'hff}, {8'h00, 8'h81, 8'h90, 8'h02});
    t_run(0, "wrap");
    chk("R7 wrapped sums", 64'(c_out), 64'({8'h05, 8'h00, 8'h10, 8'h01}));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load({8'd4, 8'd3, 8'd2, 8'd1}, {8'd40, 8'd30, 8'd20, 8'd10});
        t_run(0, "basic");
        chk("R3 basic sums", 64'(c_out), 64'({8'd44, 8'd33, 8'd22, 8'd11}));
        t_wrap();
        t_load({8'h11, 8'h22, 8'h33, 8'h44}, {8'h01, 8'h02, 8'h03, 8'h04});
        t_run(1, "busy-start");
        t_load({8'haa, 8'h55, 8'h0f, 8'hf0}, {8'h55, 8'haa, 8'hf0, 8'h0f});
        t_run(0, "pattern");
        chk("R3 pattern", 64'(c_out), 64'({8'hff, 8'hff, 8'hff, 8'hff}));
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule